// File: doc/BRIEF.md
# Dual-Channel Serial Port Host Register Front End

This block is the host-facing register file of a two-channel serial port built on the classic 16550 register layout. A host drives an 8-bit write data bus, a 3-bit register address and one active-low select per channel. Each transfer is framed by an active-low read strobe or write strobe. These strobes carry no clock relation to the block. They are brought into the system clock domain through two-flop synchronisers. A small bus state machine then turns them into one register commit per write and a registered read result per read.

Each channel holds a line control register. Its top bit switches addresses 0 and 1 from the data and interrupt-enable registers over to the two divisor bytes. Each channel also holds an interrupt-enable register with four stored bits, a scratch register and the low and high divisor bytes. When the divisor switch is on and both divisor bytes are zero, the divisor addresses return fixed identification codes instead of the stored bytes. Asserting both selects during a write updates both channels at once. A read with both selects asserted returns zero.

The bus state machine has four states. In BUS_IDLE it goes to BUS_WRITE when a select and the write strobe are seen, or to BUS_READ when a select and the read strobe are seen; a write takes priority. BUS_WRITE captures select, address and data on every cycle of the strobe and moves to BUS_COMMIT when the strobe is released. BUS_COMMIT produces the single write pulse and always returns to BUS_IDLE. BUS_READ refreshes the read result on every cycle and returns to BUS_IDLE when the read strobe is released.

Top module: `duart_hostif`

## Requirements
- R1: A qualified reset clears LCR, IER, SCR, DLL and DLM in both channels to 0x00, and the read-enable output goes low.
- R2: A reset input high for only one clock has no effect. A reset input high for three or more clocks resets the block.
- R3: A write changes the register once, after the write strobe is released. The stored value is the data present in the last sampled cycle of the strobe.
- R4: With LCR bit 7 = 0, address 1 is IER, address 3 is LCR and address 7 is SCR. IER stores only bits 3..0, and bits 7..4 read as 0.
- R5: With LCR bit 7 = 1, address 0 reads and writes DLL and address 1 reads and writes DLM. Clearing bit 7 restores the IER mapping at address 1.
- R6: With LCR bit 7 = 1 and DLL = DLM = 0x00, address 1 reads 0x0A and address 0 reads 0x01.
- R7: A write with both selects low writes the same data into the same register of both channels.
- R8: A read with both selects low returns 0x00.
- R9: Address 0 with LCR bit 7 = 0, and addresses 2, 4, 5 and 6, read as 0x00. Writes to them are not stored.
- R10: A write with only one select low leaves the other channel unchanged.
- R11: The read-enable output is high only while a selected read is in progress, and is low when the bus is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_i | input | 1 | Active-high reset request, asynchronous to clk |
| cs_a_n | input | 1 | Channel A select, active low |
| cs_b_n | input | 1 | Channel B select, active low |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read result |
| rdata_oe | output | 1 | High while the read result is valid for the host |

## Verification
The bench targets the identification overlay: it enters, leaves and re-enters it through divisor writes. A design that compared only one divisor byte, or ignored the switch bit, would return codes in place of stored divisor values. Dual-select writes and dual-select reads are checked for every channel. A design with a priority select would update only one channel, or return one channel's data instead of zero. The bench changes the data in the middle of a write strobe and sends a one-clock reset pulse. A design that sampled data at the start of the strobe, or acted on any reset edge, would show the wrong scratch value or lose its registers.

// File: rtl/duart_pkg.sv
package duart_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_READ,
        BUS_WRITE,
        BUS_COMMIT
    } bus_state_e;

    localparam logic [AW-1:0] ADR_DATA = 3'd0;
    localparam logic [AW-1:0] ADR_IEN  = 3'd1;
    localparam logic [AW-1:0] ADR_LCTL = 3'd3;
    localparam logic [AW-1:0] ADR_SCR  = 3'd7;

    localparam logic [DW-1:0] DEV_ID_CODE  = 8'h0A;
    localparam logic [DW-1:0] DEV_REV_CODE = 8'h01;
endpackage

// File: rtl/hostif_sync.sv
module hostif_sync #(
    parameter int NSEL = 2,
    parameter int AW   = 3,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_i,
    input  logic [NSEL-1:0] sel_n,
    input  logic [AW-1:0]   addr,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [DW-1:0]   wdata,
    output logic            rst_q,
    output logic [NSEL-1:0] sel_q,
    output logic [AW-1:0]   addr_q,
    output logic            rd_q,
    output logic            wr_q,
    output logic [DW-1:0]   wdata_q
);
    localparam int W = NSEL + AW + 2 + DW;

    logic [W-1:0] raw;
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [2:0]   rst_sh_q;

    // strobes and selects are inverted so an all-zero flop means "inactive"
    assign raw = {~sel_n, addr, ~rd_n, ~wr_n, wdata};

    always_ff @(posedge clk) begin
        meta_q   <= raw;
        sync_q   <= meta_q;
        rst_sh_q <= {rst_sh_q[1:0], rst_i};
        // two consecutive synchronised samples are needed to qualify reset
        rst_q    <= rst_sh_q[1] & rst_sh_q[2];
    end

    assign {sel_q, addr_q, rd_q, wr_q, wdata_q} = sync_q;
endmodule

// File: rtl/chan_regs.sv
module chan_regs
    import duart_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int IEW = 4;

    logic [DW-1:0]  lctl_q;
    logic [IEW-1:0] ien_q;
    logic [DW-1:0]  scr_q;
    logic [DW-1:0]  dlo_q;
    logic [DW-1:0]  dhi_q;
    logic           dlab;
    logic           id_mode;

    assign dlab    = lctl_q[DW-1];
    assign id_mode = dlab && (dlo_q == '0) && (dhi_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lctl_q <= '0;
            ien_q  <= '0;
            scr_q  <= '0;
            dlo_q  <= '0;
            dhi_q  <= '0;
        end else if (we) begin
            case (waddr)
                ADR_DATA: if (dlab) dlo_q <= wdata;
                ADR_IEN: begin
                    if (dlab) dhi_q <= wdata;
                    else      ien_q <= wdata[IEW-1:0];
                end
                ADR_LCTL: lctl_q <= wdata;
                ADR_SCR:  scr_q  <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (raddr)
            ADR_DATA: if (dlab) rdata = id_mode ? DEV_REV_CODE : dlo_q;
            ADR_IEN: begin
                if (dlab) rdata = id_mode ? DEV_ID_CODE : dhi_q;
                else      rdata = {{(DW-IEW){1'b0}}, ien_q};
            end
            ADR_LCTL: rdata = lctl_q;
            ADR_SCR:  rdata = scr_q;
            default:  rdata = '0;
        endcase
    end

    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(lctl_q) && $stable(ien_q) && $stable(scr_q)
                 && $stable(dlo_q) && $stable(dhi_q)));
endmodule

// File: rtl/bus_fsm.sv
module bus_fsm
    import duart_pkg::*;
#(
    parameter int NSEL = 2,
    parameter int AW   = 3,
    parameter int DW   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSEL-1:0]          sel,
    input  logic [AW-1:0]            addr,
    input  logic                     rd,
    input  logic                     wr,
    input  logic [DW-1:0]            wdata,
    input  logic [NSEL-1:0][DW-1:0]  chan_rd,
    output logic [NSEL-1:0]          wr_en,
    output logic [AW-1:0]            wr_addr,
    output logic [DW-1:0]            wr_data,
    output logic [DW-1:0]            rdata,
    output logic                     rdata_oe
);
    bus_state_e      state_q, state_d;
    logic [NSEL-1:0] sel_l;
    logic [AW-1:0]   addr_l;
    logic [DW-1:0]   data_l;
    logic [DW-1:0]   rd_mux;
    logic            multi_sel;
    logic            capture;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= BUS_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if ((|sel) && wr)      state_d = BUS_WRITE;
                else if ((|sel) && rd) state_d = BUS_READ;
            end
            BUS_WRITE:  if (!wr) state_d = BUS_COMMIT;
            BUS_COMMIT: state_d = BUS_IDLE;
            BUS_READ:   if (!rd) state_d = BUS_IDLE;
            default:    state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NSEL; i++) begin
            if (sel[i]) rd_mux = rd_mux | chan_rd[i];
        end
    end

    assign multi_sel = ($countones(sel) > 1);
    assign capture   = ((state_q == BUS_IDLE) && (state_d == BUS_WRITE))
                    || ((state_q == BUS_WRITE) && wr);

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_l    <= '0;
            addr_l   <= '0;
            data_l   <= '0;
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else begin
            rdata_oe <= (state_q == BUS_READ);
            if (state_q == BUS_READ) rdata <= multi_sel ? '0 : rd_mux;
            if (capture) begin
                sel_l  <= sel;
                addr_l <= addr;
                data_l <= wdata;
            end
        end
    end

    assign wr_en   = (state_q == BUS_COMMIT) ? sel_l : '0;
    assign wr_addr = addr_l;
    assign wr_data = data_l;

    a_r3_single_commit: assert property (@(posedge clk) disable iff (rst)
        (|wr_en) |=> (wr_en == '0));

    a_r11_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> $past(rd, 2));
endmodule

// File: rtl/duart_hostif.sv
module duart_hostif
    import duart_pkg::*;
(
    input  logic          clk,
    input  logic          rst_i,
    input  logic          cs_a_n,
    input  logic          cs_b_n,
    input  logic [AW-1:0] addr,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe
);
    localparam int NSEL = 2;

    logic                    rst_q;
    logic [NSEL-1:0]         sel_q;
    logic [AW-1:0]           addr_q;
    logic                    rd_q;
    logic                    wr_q;
    logic [DW-1:0]           wdata_q;
    logic [NSEL-1:0]         wr_en;
    logic [AW-1:0]           wr_addr;
    logic [DW-1:0]           wr_data;
    logic [NSEL-1:0][DW-1:0] chan_rd;

    hostif_sync #(.NSEL(NSEL), .AW(AW), .DW(DW)) u_sync (
        .clk     (clk),
        .rst_i   (rst_i),
        .sel_n   ({cs_b_n, cs_a_n}),
        .addr    (addr),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .wdata   (wdata),
        .rst_q   (rst_q),
        .sel_q   (sel_q),
        .addr_q  (addr_q),
        .rd_q    (rd_q),
        .wr_q    (wr_q),
        .wdata_q (wdata_q)
    );

    bus_fsm #(.NSEL(NSEL), .AW(AW), .DW(DW)) u_fsm (
        .clk      (clk),
        .rst      (rst_q),
        .sel      (sel_q),
        .addr     (addr_q),
        .rd       (rd_q),
        .wr       (wr_q),
        .wdata    (wdata_q),
        .chan_rd  (chan_rd),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    for (genvar c = 0; c < NSEL; c++) begin : g_chan
        chan_regs #(.AW(AW), .DW(DW)) u_regs (
            .clk   (clk),
            .rst   (rst_q),
            .we    (wr_en[c]),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (addr_q),
            .rdata (chan_rd[c])
        );
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst_q |=> !rdata_oe);
endmodule

// File: tb/test_duart_hostif.sv
module test_duart_hostif;
    logic       clk = 1'b0;
    logic       rst_i = 1'b0;
    logic       cs_a_n = 1'b1;
    logic       cs_b_n = 1'b1;
    logic [2:0] addr = '0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    event smp;

    always #2 clk = ~clk;

    duart_hostif i_duart_hostif (
        .clk(clk), .rst_i(rst_i), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
        .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected item when the read result is sampled
    initial begin
        forever begin
            @(smp);
            if (exp_q.size() != 0) begin
                exp_t it;
                it = exp_q.pop_front();
                chk(rdata === it.exp, it.tag, rdata, it.exp);
                chk(rdata_oe === 1'b1, {it.tag, " R11 oe"}, rdata_oe, 1);
            end
        end
    end

    task automatic do_write(input bit sa, input bit sb, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_a_n = !sa; cs_b_n = !sb; addr = a; wdata = d; wr_n = 1'b0;
        repeat (6) @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        cs_a_n = 1'b1; cs_b_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_read(input bit sa, input bit sb, input logic [2:0] a,
                           input logic [7:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        cs_a_n = !sa; cs_b_n = !sb; addr = a; rd_n = 1'b0;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        repeat (8) @(negedge clk);
        -> smp;
        @(negedge clk);
        rd_n = 1'b1;
        repeat (6) @(negedge clk);
        cs_a_n = 1'b1; cs_b_n = 1'b1;
        chk(rdata_oe === 1'b0, {tag, " R11 oe after read"}, rdata_oe, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic rst_pulse(input int n);
        @(negedge clk);
        rst_i = 1'b1;
        repeat (n) @(negedge clk);
        rst_i = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_pulse(4);
        chk(rdata_oe === 1'b0, "R11 idle oe", rdata_oe, 0);
        // R1 defaults
        do_read(1, 0, 3'd3, 8'h00, "R1 A LCR");
        do_read(1, 0, 3'd1, 8'h00, "R1 A IER");
        do_read(1, 0, 3'd7, 8'h00, "R1 A SCR");
        do_read(0, 1, 3'd7, 8'h00, "R1 B SCR");
        // R4 map
        do_write(1, 0, 3'd7, 8'hA5);
        do_read(1, 0, 3'd7, 8'hA5, "R4 A SCR");
        do_write(1, 0, 3'd1, 8'hFF);
        do_read(1, 0, 3'd1, 8'h0F, "R4 A IER low bits");
        do_write(1, 0, 3'd3, 8'h03);
        do_read(1, 0, 3'd3, 8'h03, "R4 A LCR");
        // R10 isolation
        do_read(0, 1, 3'd7, 8'h00, "R10 B SCR untouched");
        do_read(0, 1, 3'd1, 8'h00, "R10 B IER untouched");
        // R6 identification
        do_write(1, 0, 3'd3, 8'h83);
        do_read(1, 0, 3'd1, 8'h0A, "R6 id code");
        do_read(1, 0, 3'd0, 8'h01, "R6 rev code");
        // R5 divisor access
        do_write(1, 0, 3'd0, 8'h34);
        do_read(1, 0, 3'd0, 8'h34, "R5 DLL");
        do_read(1, 0, 3'd1, 8'h00, "R5 DLM");
        do_write(1, 0, 3'd0, 8'h00);
        do_read(1, 0, 3'd1, 8'h0A, "R6 id again");
        do_write(1, 0, 3'd1, 8'h12);
        do_read(1, 0, 3'd1, 8'h12, "R5 DLM stored");
        do_read(1, 0, 3'd0, 8'h00, "R5 DLL zero");
        do_write(1, 0, 3'd3, 8'h03);
        do_read(1, 0, 3'd1, 8'h0F, "R5 IER restored");
        // R9 unimplemented
        do_read(1, 0, 3'd0, 8'h00, "R9 addr0 no dlab");
        do_read(1, 0, 3'd2, 8'h00, "R9 addr2");
        do_write(1, 0, 3'd4, 8'hFF);
        do_read(1, 0, 3'd4, 8'h00, "R9 addr4 write dropped");
        do_write(1, 0, 3'd6, 8'hFF);
        do_read(1, 0, 3'd6, 8'h00, "R9 addr6 write dropped");
        do_read(1, 0, 3'd5, 8'h00, "R9 addr5");
        // R7 dual write
        do_write(1, 1, 3'd7, 8'h3C);
        do_read(1, 0, 3'd7, 8'h3C, "R7 A SCR");
        do_read(0, 1, 3'd7, 8'h3C, "R7 B SCR");
        // R8 dual read
        do_read(1, 1, 3'd7, 8'h00, "R8 dual read");
        do_read(0, 1, 3'd7, 8'h3C, "R8 B unchanged");
        // R3 data changing during strobe: last sampled value wins
        @(negedge clk);
        cs_b_n = 1'b0; addr = 3'd7; wdata = 8'h11; wr_n = 1'b0;
        repeat (5) @(negedge clk);
        wdata = 8'h77;
        repeat (5) @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        cs_b_n = 1'b1;
        repeat (2) @(negedge clk);
        do_read(0, 1, 3'd7, 8'h77, "R3 last data stored");
        do_read(1, 0, 3'd7, 8'h3C, "R10 A after B write");
        // R2 reset qualification
        rst_pulse(1);
        do_read(1, 0, 3'd7, 8'h3C, "R2 short pulse ignored");
        do_read(1, 0, 3'd3, 8'h03, "R2 short pulse LCR kept");
        rst_pulse(3);
        do_read(1, 0, 3'd7, 8'h00, "R2 long pulse SCR");
        do_read(1, 0, 3'd3, 8'h00, "R1 LCR after reset");
        do_read(0, 1, 3'd7, 8'h00, "R1 B SCR after reset");
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule